// File: doc/BRIEF.md
# Streaming Hamming ECC Generator for 256-Byte Steps

This block sits beside the data path of a flash page transfer and watches every data byte that crosses it, in either direction. Over each step of 256 accepted bytes it folds the bytes into a single-error-correcting Hamming parity word. That word is made of column parity, which locates a bit inside a byte, and line parity, which locates a byte inside the step. When the last byte of a step is accepted, the block latches the finished word, raises a one-clock result flag and starts the next step from zero. A host or DMA engine reads the latched word at that point.

For storage, the block also presents the word in the form written to the spare area. The raw word is moved up by two bits and inverted, and the 24-bit result is split into three bytes, most significant first. The block only computes codes. Correcting errors and handling spare-area bytes are left to the surrounding logic, which keeps the enable low while spare bytes pass. A clear pulse before each page transfer throws away any partial step.

Top module: `hamming_step_ecc`

## Requirements
- R1: A step is complete when 256 bytes have been accepted. On the clock edge that accepts the 256th byte, `ecc_word` is loaded and `ecc_valid` goes high for exactly one cycle. Before that edge, `ecc_valid` stays low.
- R2: Bits 5:0 of `ecc_word` hold the column parity. For bit-position index bit k (k = 0..2), bit 2k is the XOR of all step data bits whose position within the byte has bit k = 0. Bit 2k+1 is the same XOR over positions with bit k = 1.
- R3: Bits 21:6 of `ecc_word` hold the line parity. For byte-index bit j (j = 0..7), bit 6+2j is the XOR of every bit of the bytes whose index within the step has bit j = 0. Bit 7+2j is the same XOR over indices with bit j = 1.
- R4: A byte is accepted only on a cycle with both `byte_vld` and `ecc_en` high. Any other cycle leaves the step count and the parity unchanged, whatever is on `byte_data`.
- R5: A cycle with `ecc_clr` high discards the partial step, so the next accepted byte has index 0. A byte presented in the same cycle as the clear is dropped, and the clear never raises `ecc_valid`.
- R6: After each result, accumulation starts over, so back-to-back steps give codes that depend only on their own bytes.
- R7: `ecc_word` holds its value until the next completed step. A clear does not alter it.
- R8: `{code_hi, code_mid, code_lo}` equals the bitwise inverse of `{ecc_word, 2'b00}`, taken as 24 bits. `code_hi` carries bits 23:16, `code_mid` bits 15:8 and `code_lo` bits 7:0, so `code_lo[1:0]` is always 2'b11.
- R9: After reset, `ecc_word` is 0, `ecc_valid` is 0 and the step count is 0, which makes the three code bytes 0xFF.
- R10: Take two steps that differ in one bit, at byte index i and bit position b. The XOR of their codes has exactly 11 bits set, one in every parity pair. The odd-numbered members of that XOR spell out b in the column pairs and i in the line pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ecc_en | input | 1 | Parity enable; low while spare-area bytes pass |
| ecc_clr | input | 1 | Pulse that restarts the current step |
| byte_vld | input | 1 | Byte strobe for `byte_data` |
| byte_data | input | 8 | Data byte of the page data area |
| ecc_word | output | 22 | Latched raw parity word of the last completed step |
| ecc_valid | output | 1 | One-cycle pulse when `ecc_word` has been loaded |
| code_hi | output | 8 | Stored-form code, bits 23:16 |
| code_mid | output | 8 | Stored-form code, bits 15:8 |
| code_lo | output | 8 | Stored-form code, bits 7:0 |

## Verification
The bench computes each expected code arithmetically from the step bytes and compares it against the outputs. It does this for zero, all-ones, counting and pseudo-random steps, run back to back and with idle and enable-low cycles mixed in. An off-by-one step counter would raise the flag a cycle early or late, and a lost restart would leak one step's parity into the next. A sweep of single-bit flips over a random base step checks that the code difference pinpoints the flipped byte and bit; a swapped even/odd pair or a misrouted index bit would point to the wrong location. A clear that lands together with a byte catches a design that keeps that byte or disturbs the latched word.

// File: rtl/hecc_pkg.sv
// Shared defaults and helpers for the streaming Hamming ECC generator.
// Assumes byte width and step length are powers of two.
package hecc_pkg;
    localparam int DEF_DATA_W     = 8;
    localparam int DEF_STEP_BYTES = 256;
    localparam int CODE_BYTES     = 3;

    // Mask of the bit positions in a byte whose index has bit k set.
    function automatic logic [DEF_DATA_W-1:0] pos_mask(input int k);
        logic [DEF_DATA_W-1:0] m;
        for (int b = 0; b < DEF_DATA_W; b++) begin
            m[b] = ((b >> k) & 1) != 0;
        end
        return m;
    endfunction
endpackage

// File: rtl/hecc_col_parity.sv
// Column parity of one byte: an even/odd pair per bit-position index bit,
// plus the XOR of the whole byte used by the line parity.
// Assumes DATA_W equals the package default so pos_mask lines up.
module hecc_col_parity #(
    parameter int DATA_W = hecc_pkg::DEF_DATA_W,
    localparam int CB    = $clog2(DATA_W),
    localparam int COL_W = 2 * CB
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [COL_W-1:0]  col_o,
    output logic              bpar_o
);
    // Whole-byte parity feeds every line pair.
    assign bpar_o = ^data_i;

    // One pair of column parities per position index bit.
    for (genvar k = 0; k < CB; k++) begin : g_col
        localparam logic [DATA_W-1:0] MASK = hecc_pkg::pos_mask(k);
        assign col_o[2*k]   = ^(data_i & ~MASK);
        assign col_o[2*k+1] = ^(data_i & MASK);
    end
endmodule

// File: rtl/hecc_step_counter.sv
// Byte index within the current step; flags the final byte.
// Assumes STEP_BYTES is a power of two so the index wraps on its own.
module hecc_step_counter #(
    parameter int STEP_BYTES = hecc_pkg::DEF_STEP_BYTES,
    localparam int IDX_W     = $clog2(STEP_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             take_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);
    // Index register: cleared by reset or clear, advanced per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            idx_o <= '0;
        end else if (take_i) begin
            idx_o <= idx_o + 1'b1;
        end
    end

    // Final byte of the step.
    assign last_o = (idx_o == IDX_W'(STEP_BYTES - 1));
endmodule

// File: rtl/hecc_accum.sv
// Running column and line parity; latches the finished word at step end.
// Assumes idx_i and last_i come from the step counter of the same cycle.
module hecc_accum #(
    parameter int IDX_W = 8,
    parameter int COL_W = 6,
    localparam int LINE_W = 2 * IDX_W,
    localparam int ECC_W  = COL_W + LINE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             take_i,
    input  logic             last_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             bpar_i,
    output logic [ECC_W-1:0] ecc_o,
    output logic             valid_o
);
    logic [COL_W-1:0]  col_run;
    logic [LINE_W-1:0] line_run;
    logic [LINE_W-1:0] line_inc;
    logic [COL_W-1:0]  col_nx;
    logic [LINE_W-1:0] line_nx;

    // Route byte parity to the even or odd member of each line pair.
    for (genvar j = 0; j < IDX_W; j++) begin : g_line
        assign line_inc[2*j]   = bpar_i & ~idx_i[j];
        assign line_inc[2*j+1] = bpar_i &  idx_i[j];
    end

    assign col_nx  = col_run ^ col_i;
    assign line_nx = line_run ^ line_inc;

    // Accumulate, and on the final byte latch the word and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_run  <= '0;
            line_run <= '0;
            ecc_o    <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (clr_i) begin
                col_run  <= '0;
                line_run <= '0;
            end else if (take_i) begin
                if (last_i) begin
                    ecc_o    <= {line_nx, col_nx};
                    valid_o  <= 1'b1;
                    col_run  <= '0;
                    line_run <= '0;
                end else begin
                    col_run  <= col_nx;
                    line_run <= line_nx;
                end
            end
        end
    end
endmodule

// File: rtl/hecc_format.sv
// Stored-form conversion: raw word moved up two bits, inverted, 24 bits.
// Assumes nothing about timing; purely combinational.
module hecc_format #(
    parameter int ECC_W  = 22,
    localparam int CODE_W = 8 * hecc_pkg::CODE_BYTES,
    localparam int SH_W   = ECC_W + 2
) (
    input  logic [ECC_W-1:0]  ecc_i,
    output logic [CODE_W-1:0] code_o
);
    logic [SH_W-1:0] shifted;
    assign shifted = {ecc_i, 2'b00};

    // Truncate or zero-extend to the stored width, then invert.
    if (SH_W >= CODE_W) begin : g_trunc
        assign code_o = ~shifted[CODE_W-1:0];
    end else begin : g_pad
        assign code_o = ~{{(CODE_W - SH_W){1'b0}}, shifted};
    end
endmodule

// File: rtl/hamming_step_ecc.sv
// Top: streaming Hamming ECC generator over fixed-length byte steps.
// Accepts a byte when byte_vld and ecc_en are both high; ecc_clr restarts
// the step and wins over a byte in the same cycle.
// Assumes DATA_W and STEP_BYTES are powers of two.
module hamming_step_ecc #(
    parameter int DATA_W     = hecc_pkg::DEF_DATA_W,
    parameter int STEP_BYTES = hecc_pkg::DEF_STEP_BYTES,
    localparam int IDX_W  = $clog2(STEP_BYTES),
    localparam int COL_W  = 2 * $clog2(DATA_W),
    localparam int ECC_W  = COL_W + 2 * IDX_W,
    localparam int CODE_W = 8 * hecc_pkg::CODE_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en,
    input  logic              ecc_clr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    output logic [ECC_W-1:0]  ecc_word,
    output logic              ecc_valid,
    output logic [7:0]        code_hi,
    output logic [7:0]        code_mid,
    output logic [7:0]        code_lo
);
    logic             take;
    logic [IDX_W-1:0] idx;
    logic             last;
    logic [COL_W-1:0] col;
    logic             bpar;
    logic [CODE_W-1:0] code;

    assign take = byte_vld & ecc_en & ~ecc_clr;

    hecc_col_parity #(.DATA_W(DATA_W)) u_col (
        .data_i (byte_data),
        .col_o  (col),
        .bpar_o (bpar)
    );

    hecc_step_counter #(.STEP_BYTES(STEP_BYTES)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ecc_clr),
        .take_i (take),
        .idx_o  (idx),
        .last_o (last)
    );

    hecc_accum #(.IDX_W(IDX_W), .COL_W(COL_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (ecc_clr),
        .take_i  (take),
        .last_i  (last),
        .idx_i   (idx),
        .col_i   (col),
        .bpar_i  (bpar),
        .ecc_o   (ecc_word),
        .valid_o (ecc_valid)
    );

    hecc_format #(.ECC_W(ECC_W)) u_fmt (
        .ecc_i  (ecc_word),
        .code_o (code)
    );

    assign code_hi  = code[23:16];
    assign code_mid = code[15:8];
    assign code_lo  = code[7:0];
endmodule

// File: rtl/hecc_checker.sv
// Assertion checker for hamming_step_ecc, attached by bind below.
// Assumes synchronous active-low reset held for at least one edge.
module hecc_checker #(
    parameter int ECC_W = 22,
    localparam int NPAIR = ECC_W / 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ecc_en,
    input logic             ecc_clr,
    input logic             byte_vld,
    input logic [ECC_W-1:0] ecc_word,
    input logic             ecc_valid,
    input logic [7:0]       code_lo
);
    logic [NPAIR-1:0] pair_x;
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pair_x[p] = ecc_word[2*p] ^ ecc_word[2*p+1];
    end

    // R1: the result flag lasts one cycle.
    assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_valid |=> !ecc_valid);

    // R4: a result only follows an accepted byte.
    assert_valid_needs_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_valid |-> $past(byte_vld && ecc_en && !ecc_clr));

    // R5: a clear never produces a result.
    assert_clr_no_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_clr |=> !ecc_valid);

    // R7: the latched word only moves together with the result flag.
    assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_valid |-> $stable(ecc_word));

    // R8: the two lowest stored bits are always ones.
    assert_code_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        code_lo[1:0] == 2'b11);

    // R10: every parity pair splits the same total step parity.
    assert_pair_parity_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_valid |-> (pair_x == '0 || pair_x == '1));
endmodule

bind hamming_step_ecc hecc_checker #(.ECC_W(ECC_W)) u_hecc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ecc_en    (ecc_en),
    .ecc_clr   (ecc_clr),
    .byte_vld  (byte_vld),
    .ecc_word  (ecc_word),
    .ecc_valid (ecc_valid),
    .code_lo   (code_lo)
);

// File: tb/tb_hamming_step_ecc.sv
module tb_hamming_step_ecc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_en = 1'b0;
    logic        ecc_clr = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [21:0] ecc_word;
    logic        ecc_valid;
    logic [7:0]  code_hi, code_mid, code_lo;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] mem_q [256];

    always #4 clk = ~clk;

    hamming_step_ecc dut (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .ecc_clr(ecc_clr),
        .byte_vld(byte_vld), .byte_data(byte_data), .ecc_word(ecc_word),
        .ecc_valid(ecc_valid), .code_hi(code_hi), .code_mid(code_mid),
        .code_lo(code_lo)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Arithmetic model of the raw parity word over mem_q.
    function automatic logic [21:0] model_ecc();
        logic [5:0]  col = '0;
        logic [15:0] line = '0;
        for (int i = 0; i < 256; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (mem_q[i][b]) begin
                    for (int k = 0; k < 3; k++) col[2*k + ((b >> k) & 1)] ^= 1'b1;
                    for (int j = 0; j < 8; j++) line[2*j + ((i >> j) & 1)] ^= 1'b1;
                end
            end
        end
        return {line, col};
    endfunction

    task automatic cycle(input logic v, input logic e, input logic [7:0] d, inout bit early);
        @(negedge clk);
        if (ecc_valid) early = 1'b1;
        byte_vld = v; ecc_en = e; byte_data = d;
    endtask

    // Feed mem_q as one step; gaps add idle and enable-low junk cycles.
    task automatic run_step(input bit gaps, output logic [21:0] got);
        logic [21:0] exp;
        logic [23:0] code_exp;
        bit early = 1'b0;
        exp = model_ecc();
        for (int i = 0; i < 256; i++) begin
            if (gaps && (i % 5 == 2)) begin
                cycle(1'b0, 1'b1, 8'($urandom), early);
                cycle(1'b1, 1'b0, 8'($urandom), early);
            end
            cycle(1'b1, 1'b1, mem_q[i], early);
        end
        @(negedge clk);
        byte_vld = 1'b0;
        check(!early, "R1 no early valid", 32'(early), 32'd0);
        check(ecc_valid == 1'b1, "R1 valid after 256th byte", 32'(ecc_valid), 32'd1);
        check(ecc_word == exp, gaps ? "R4 word with gaps" : "R2 R3 word", 32'(ecc_word), 32'(exp));
        code_exp = ~{exp, 2'b00};
        check({code_hi, code_mid, code_lo} == code_exp, "R8 stored code",
              32'({code_hi, code_mid, code_lo}), 32'(code_exp));
        got = ecc_word;
        @(negedge clk);
        check(ecc_valid == 1'b0, "R1 single-cycle valid", 32'(ecc_valid), 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin : main
        logic [21:0] r0, r1, base;
        logic [21:0] x;
        logic [21:0] hold;
        bit dummy;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check(ecc_valid == 1'b0, "R9 reset valid", 32'(ecc_valid), 32'd0);
        check(ecc_word == '0, "R9 reset word", 32'(ecc_word), 32'd0);
        check({code_hi, code_mid, code_lo} == 24'hFFFFFF, "R9 reset code",
              32'({code_hi, code_mid, code_lo}), 32'hFFFFFF);
        rst_n = 1'b1;

        for (int i = 0; i < 256; i++) mem_q[i] = 8'h00;
        run_step(1'b0, r0);
        for (int i = 0; i < 256; i++) mem_q[i] = 8'hFF;
        run_step(1'b0, r0);
        for (int i = 0; i < 256; i++) mem_q[i] = 8'(i);
        run_step(1'b1, r0);
        // R6 back to back, no idle between steps beyond the check cycles
        for (int i = 0; i < 256; i++) mem_q[i] = 8'($urandom);
        run_step(1'b0, r0);
        for (int i = 0; i < 256; i++) mem_q[i] = 8'(i * 37 + 11);
        run_step(1'b0, r1);
        check(r1 == model_ecc(), "R6 second step independent", 32'(r1), 32'(model_ecc()));

        // R5 / R7 clear mid-step, colliding with a byte
        hold = ecc_word;
        dummy = 1'b0;
        for (int i = 0; i < 100; i++) cycle(1'b1, 1'b1, 8'($urandom), dummy);
        @(negedge clk);
        byte_vld = 1'b1; ecc_en = 1'b1; ecc_clr = 1'b1; byte_data = 8'hA5;
        @(negedge clk);
        ecc_clr = 1'b0; byte_vld = 1'b0;
        check(ecc_valid == 1'b0, "R5 clear gives no valid", 32'(ecc_valid), 32'd0);
        check(ecc_word == hold, "R7 clear keeps word", 32'(ecc_word), 32'(hold));
        for (int i = 0; i < 256; i++) mem_q[i] = 8'($urandom);
        run_step(1'b0, r0);
        check(r0 == model_ecc(), "R5 step after clear", 32'(r0), 32'(model_ecc()));

        // R10 single-bit flip sweep over a random base
        for (int i = 0; i < 256; i++) mem_q[i] = 8'($urandom);
        run_step(1'b0, base);
        for (int pos = 0; pos < 2048; pos += 47) begin
            logic [7:0] ix;
            logic [2:0] bp;
            ix = 8'(pos >> 3);
            bp = 3'(pos & 7);
            mem_q[ix][bp] = ~mem_q[ix][bp];
            run_step(1'b0, r1);
            x = base ^ r1;
            check($countones(x) == 11, "R10 flip weight", 32'($countones(x)), 32'd11);
            check({x[21], x[19], x[17], x[15], x[13], x[11], x[9], x[7]} == ix,
                  "R10 flip byte index",
                  32'({x[21], x[19], x[17], x[15], x[13], x[11], x[9], x[7]}), 32'(ix));
            check({x[5], x[3], x[1]} == bp, "R10 flip bit position",
                  32'({x[5], x[3], x[1]}), 32'(bp));
            mem_q[ix][bp] = ~mem_q[ix][bp];
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule